// File: doc/BRIEF.md
# SPI Byte Master with Overrun Hold and Write-Collision Flag

This block is a single-byte SPI master for a CPU bus. The byte written to the data address goes into a shift engine and is sent MSB first on MOSI. SS is held low for the whole transfer, and the byte returned on MISO is collected at the same time. SCK idles low. MOSI changes only after falling edges, and MISO is sampled on rising edges. A power-of-two divider sets the length of each SCK half period, counted in system clocks.

The data address acts as the transmit register on writes and as the receive buffer on reads. Two sticky flags report what happened. The done flag sets when a transfer ends and also drives the level interrupt output. The clash flag sets when software writes the data address while a transfer is still running. That write is thrown away. Both flags are cleared by the same two-step sequence: a status read that sees the flag set, then any access to the data address. While done stays unserviced, the bytes from later transfers are dropped and the buffer keeps the first unread byte.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the data address and the status address both read 0x00, the divider address reads 0x00, ss_no is high, sck_o is low and irq_o is low.
- R2: A write to the data address (addr 0) while idle starts an 8-bit transfer with that byte, sent MSB first. ss_no stays low for the whole transfer and sck_o idles low. MOSI holds steady while SCK is high and changes only after a falling edge.
- R3: MISO is sampled on each SCK rising edge, MSB first. When the transfer ends, the received byte can be read at the data address, provided done was clear at that moment.
- R4: Status bit 0 (busy) is 1 from the cycle after the starting write until the transfer ends. Status bit 7 (done) and irq_o go to 1 on the same clock edge at which ss_no returns high.
- R5: A write to the data address while busy sets status bit 6 (clash). The write has no other effect: the byte being sent does not change and no second transfer follows.
- R6: While done is set, the byte from any further completed transfer is dropped. The data address keeps returning the first unread byte until done is cleared. After done is cleared, the next transfer loads its byte normally.
- R7: Done clears only when a status read that returns done=1 is followed by a read or write of the data address. A data access with no such status read before it leaves done (and irq_o) set.
- R8: Clash clears by the same sequence: a status read that returns clash=1, then a data access. A data access with no such status read before it leaves clash set.
- R9: A write to addr 2 sets the divider exponent e from bits [2:0], and addr 2 reads e back. Each SCK half period lasts 2^e clocks, so ss_no stays low for 16*2^e clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 2 | 0 data, 1 status, 2 divider, 3 reads zero |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational on the address |
| irq_o | output | 1 | Level interrupt, equal to the done flag |
| sck_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data out |
| ss_no | output | 1 | Slave select, active low |
| miso_i | input | 1 | Serial data in |

## Verification
A loopback slave model returns a preset byte while it captures the byte it was sent. A monitor compares each captured byte against the queued expected byte. This catches bit-order errors and any transfer that a collided write starts when it should have been dropped. The bench sends three transfers without servicing done and expects the first received byte back. A design that overwrites the buffer instead returns the last byte. The clear sequence is also tested out of order: a data access with no status read before it must leave both flags standing, so a design that clears on any access fails. The length of SS low at several divider settings exposes off-by-one errors in the divider or the phase count.

// File: rtl/spi_dr_pkg.sv
package spi_dr_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_STAT = 2'd1,
    REG_DIV  = 2'd2,
    REG_RSVD = 2'd3
  } reg_sel_e;

  localparam int unsigned STAT_BUSY_BIT = 0;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int unsigned EXP_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);
  localparam int unsigned MAX_EXP = (1 << EXP_W) - 1;
  localparam int unsigned CNT_W   = MAX_EXP + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_m1;

  assign half_m1 = (CNT_W'(1) << exp_i) - CNT_W'(1);
  assign tick_o  = run_i && (cnt_q >= half_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + CNT_W'(1);
  end

  // consecutive ticks only when the half period is a single clock
  assert_tick_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && exp_i != '0) |=> (!tick_o || exp_i != $past(exp_i)));
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              active_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              ss_no,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int unsigned PH_N = 2 * DATA_W;
  localparam int unsigned PH_W = $clog2(PH_N);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PH_N - 1);

  logic              active_q, sck_q;
  logic [DATA_W-1:0] tx_sh_q, rx_sh_q;
  logic [PH_W-1:0]   ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      tx_sh_q  <= '0;
      rx_sh_q  <= '0;
      ph_q     <= '0;
    end else if (start_i && !active_q) begin
      active_q <= 1'b1;
      sck_q    <= 1'b0;
      tx_sh_q  <= tx_i;
      ph_q     <= '0;
    end else if (active_q && tick_i) begin
      ph_q <= ph_q + 1'b1;
      if (!sck_q) begin
        sck_q   <= 1'b1;
        rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso_i};
      end else begin
        sck_q   <= 1'b0;
        tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
        if (ph_q == PH_LAST) active_q <= 1'b0;
      end
    end
  end

  assign active_o = active_q;
  assign sck_o    = sck_q;
  assign mosi_o   = tx_sh_q[DATA_W-1];
  assign ss_no    = ~active_q;
  assign done_o   = active_q && tick_i && sck_q && (ph_q == PH_LAST);
  assign rx_o     = rx_sh_q;

  assert_sck_idle_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> !sck_q);

  assert_mosi_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && $past(active_q) && (mosi_o != $past(mosi_o))) |-> $fell(sck_q));
endmodule

// File: rtl/spi_reg_if.sv
module spi_reg_if
  import spi_dr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned EXP_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              active_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rx_i,
  output logic              start_o,
  output logic [DATA_W-1:0] tx_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic              done_o
);
  logic              done_q, done_arm_q, clash_q, clash_arm_q;
  logic [DATA_W-1:0] rx_buf_q;
  logic [EXP_W-1:0]  exp_q;
  logic              data_acc, data_wr, stat_rd, div_wr;
  logic [DATA_W-1:0] stat_vec;

  assign data_acc = sel_i && (addr_i == REG_DATA);
  assign data_wr  = data_acc && wr_i;
  assign stat_rd  = sel_i && !wr_i && (addr_i == REG_STAT);
  assign div_wr   = sel_i && wr_i && (addr_i == REG_DIV);

  assign start_o = data_wr && !active_i;
  assign tx_o    = wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q      <= 1'b0;
      done_arm_q  <= 1'b0;
      clash_q     <= 1'b0;
      clash_arm_q <= 1'b0;
      rx_buf_q    <= '0;
      exp_q       <= '0;
    end else begin
      if (div_wr) exp_q <= wdata_i[EXP_W-1:0];
      // overrun: keep first unread byte
      if (done_i && !done_q) rx_buf_q <= rx_i;

      if (done_i)                        done_q <= 1'b1;
      else if (data_acc && done_arm_q)   done_q <= 1'b0;
      if (data_acc)                      done_arm_q <= 1'b0;
      else if (stat_rd && done_q)        done_arm_q <= 1'b1;

      if (data_wr && active_i)           clash_q <= 1'b1;
      else if (data_acc && clash_arm_q)  clash_q <= 1'b0;
      if (data_acc)                      clash_arm_q <= 1'b0;
      else if (stat_rd && clash_q)       clash_arm_q <= 1'b1;
    end
  end

  always_comb begin
    stat_vec                = '0;
    stat_vec[DATA_W-1]      = done_q;
    stat_vec[DATA_W-2]      = clash_q;
    stat_vec[STAT_BUSY_BIT] = active_i;
  end

  always_comb begin
    unique case (addr_i)
      REG_DATA: rdata_o = rx_buf_q;
      REG_STAT: rdata_o = stat_vec;
      REG_DIV:  rdata_o = DATA_W'(exp_q);
      default:  rdata_o = '0;
    endcase
  end

  assign exp_o  = exp_q;
  assign done_o = done_q;

  assert_clash_on_busy_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && active_i) |=> clash_q);

  assert_overrun_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && done_q) |=> $stable(rx_buf_q));

  assert_done_from_engine_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(done_i));

  assert_done_clear_armed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_q) |-> $past(done_arm_q));

  assert_clash_clear_armed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clash_q) |-> $past(clash_arm_q));
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned EXP_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              ss_no,
  input  logic              miso_i
);
  logic              start, active, tick, done_pulse;
  logic [DATA_W-1:0] tx_byte, rx_byte;
  logic [EXP_W-1:0]  div_exp;

  spi_reg_if #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (bus_sel_i),
    .wr_i     (bus_wr_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .rdata_o  (bus_rdata_o),
    .active_i (active),
    .done_i   (done_pulse),
    .rx_i     (rx_byte),
    .start_o  (start),
    .tx_o     (tx_byte),
    .exp_o    (div_exp),
    .done_o   (irq_o)
  );

  spi_clk_div #(.EXP_W(EXP_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (active),
    .exp_i  (div_exp),
    .tick_o (tick)
  );

  spi_shift_eng #(.DATA_W(DATA_W)) u_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .tx_i     (tx_byte),
    .tick_i   (tick),
    .miso_i   (miso_i),
    .active_o (active),
    .sck_o    (sck_o),
    .mosi_o   (mosi_o),
    .ss_no    (ss_no),
    .done_o   (done_pulse),
    .rx_o     (rx_byte)
  );

  assert_ss_low_while_clocking_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> !ss_no);
endmodule

// File: tb/spi_byte_master_tb_top.sv
module spi_byte_master_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, sck, mosi, ss_n, miso;

  int checks = 0, errors = 0, cyc = 0, mode_err = 0;
  logic [7:0] exp_tx_q[$];

  always #5 clk = ~clk;

  spi_byte_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .sck_o(sck), .mosi_o(mosi), .ss_no(ss_n), .miso_i(miso)
  );

  // loopback slave
  logic [7:0] sreg = 8'h00, slave_next = 8'h00;
  logic       cap = 1'b0;
  always @(negedge ss_n) sreg = slave_next;
  always @(posedge sck) cap = mosi;
  always @(negedge sck) sreg = {sreg[6:0], cap};
  assign miso = sreg[7];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: compare each finished transfer with the scoreboard
  logic prev_ss = 1'b1, prev_sck = 1'b0, prev_mosi = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!prev_ss && ss_n) begin
        if (exp_tx_q.size() == 0) chk("R5 unexpected transfer", 1, 0);
        else chk("R2 slave captured byte", sreg, exp_tx_q.pop_front());
      end
      if (!ss_n && sck && prev_sck && mosi != prev_mosi) mode_err++;
    end
    prev_ss = ss_n; prev_sck = sck; prev_mosi = mosi;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 1'b0;
  endtask

  task automatic start_xfer(input logic [7:0] tx, input logic [7:0] slv);
    slave_next = slv;
    exp_tx_q.push_back(tx);
    bus_write(2'd0, tx);
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] slv, input int len);
    int n = 0;
    start_xfer(tx, slv);
    while (ss_n == 1'b0) begin n++; @(negedge clk); end
    chk("R9 ss low cycles", n, len);
    chk("R4 irq with ss release", irq, 1);
  endtask

  logic [7:0] rd;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ss_no", ss_n, 1);
    chk("R1 sck_o", sck, 0);
    chk("R1 irq_o", irq, 0);
    bus_read(2'd0, rd); chk("R1 data", rd, 8'h00);
    bus_read(2'd1, rd); chk("R1 status", rd, 8'h00);
    bus_read(2'd2, rd); chk("R1 divider", rd, 8'h00);

    // basic transfers at several dividers
    xfer(8'hA5, 8'h3C, 16);
    bus_read(2'd1, rd); chk("R4 status done", rd, 8'h80);
    bus_read(2'd0, rd); chk("R3 rx 3C", rd, 8'h3C);
    bus_read(2'd1, rd); chk("R7 done cleared", rd, 8'h00);

    bus_write(2'd2, 8'h01);
    bus_read(2'd2, rd); chk("R9 divider readback", rd, 8'h01);
    xfer(8'h80, 8'h01, 32);
    bus_read(2'd1, rd); chk("R4 status done", rd, 8'h80);
    bus_read(2'd0, rd); chk("R3 rx 01", rd, 8'h01);

    bus_write(2'd2, 8'h03);
    xfer(8'h00, 8'hFF, 128);
    bus_read(2'd1, rd);
    bus_read(2'd0, rd); chk("R3 rx FF", rd, 8'hFF);
    bus_read(2'd1, rd); chk("R7 cleared", rd, 8'h00);

    // collision
    bus_write(2'd2, 8'h02);
    start_xfer(8'h69, 8'hC6);
    bus_read(2'd1, rd); chk("R4 busy mid transfer", rd, 8'h01);
    bus_write(2'd0, 8'h12);
    bus_read(2'd0, rd);
    while (ss_n == 1'b0) @(negedge clk);
    bus_read(2'd0, rd); chk("R3 rx after clash", rd, 8'hC6);
    chk("R7 done kept without status read", irq, 1);
    bus_read(2'd1, rd); chk("R8 clash kept without status read", rd, 8'hC0);
    bus_read(2'd0, rd); chk("R5 rx unaffected", rd, 8'hC6);
    bus_read(2'd1, rd); chk("R8 clash and done cleared", rd, 8'h00);
    begin
      int lows = 0;
      repeat (40) begin @(negedge clk); if (!ss_n) lows++; end
      chk("R5 no transfer from dropped write", lows, 0);
    end

    // overrun retention
    bus_write(2'd2, 8'h00);
    xfer(8'h11, 8'hC3, 16);
    xfer(8'h22, 8'h5A, 16);
    chk("R7 done kept after unarmed write", irq, 1);
    xfer(8'h33, 8'h96, 16);
    bus_read(2'd1, rd); chk("R6 status", rd, 8'h80);
    bus_read(2'd0, rd); chk("R6 first byte kept", rd, 8'hC3);
    bus_read(2'd1, rd); chk("R6 done cleared", rd, 8'h00);
    xfer(8'h44, 8'h69, 16);
    bus_read(2'd1, rd);
    bus_read(2'd0, rd); chk("R6 fresh byte after service", rd, 8'h69);

    repeat (4) @(negedge clk);
    chk("R2 mosi stable while sck high", mode_err, 0);
    chk("R2 scoreboard drained", exp_tx_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule